// File: doc/BRIEF.md
# HDLC Shared-Bus Access Controller

This block is a bit-serial HDLC frame transmitter for a multi-drop line on which every station drives through an open-drain output, so the line is the wired-AND of all drivers. A host writes one frame as a burst of bytes into a local frame store. The block then watches the echoed line value for a run of idle ones. Once the run is long enough, it sends an opening flag, the frame bytes with zero-bit insertion, and a closing flag.

One bit is sent per transmit clock cycle. On every rising edge the block samples the echoed line and compares it with the bit it is driving. If it drove a one and sees a zero, another station owns the line. The block then releases the line at once, counts the lost arbitration, and goes back to waiting for idle. It replays the stored frame from its opening flag with no help from the host. A one-cycle completion pulse marks every frame that reaches the end of its closing flag intact.

Top module: `hdlc_bus_tx`

## Requirements
- R1: After reset, `txd` is 1, `done` and `coll` are 0, `coll_cnt` is 0 and `in_ready` is 1.
- R2: A byte is taken on a rising edge when `in_valid` and `in_ready` are both 1. `in_sof` places that byte at the frame start and drops earlier unfinished bytes. A byte with `in_eof`, or the byte that fills the last of DEPTH slots, ends the frame. `in_ready` then stays 0 and further bytes are ignored until the frame has been sent.
- R3: With a frame pending, `txd` stays 1 until IDLE_ONES (8) consecutive ones have been sampled on `cts` at rising edges, and any sampled 0 restarts that count. The first flag bit appears on `txd` in the cycle after the edge that sampled the eighth one.
- R4: A frame on `txd` is the flag 0x7E, then the data bytes, then the flag 0x7E, all sent least significant bit first.
- R5: After five consecutive data ones, including a run that spans a byte boundary or ends the last byte, one 0 is inserted. Flag bits are never followed by an inserted 0.
- R6: A driven 0 that is echoed as 0 is not a collision. Transmission goes on and `coll_cnt` is unchanged.
- R7: When `txd` is 1 and `cts` is 0 at a rising edge during a frame, then in the next cycle `txd` is 1, `coll` is 1 for one cycle, and `coll_cnt` has risen by one.
- R8: After a lost arbitration, the block waits again for IDLE_ONES ones and resends the whole stored frame from its opening flag, with no new host input.
- R9: `done` is 1 for exactly one cycle, in the cycle after the last closing-flag bit. `in_ready` is 1 again in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit bit clock, one bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Frame byte from the host |
| in_valid | input | 1 | `in_data` holds a byte |
| in_sof | input | 1 | This byte is the first of a frame |
| in_eof | input | 1 | This byte is the last of a frame |
| in_ready | output | 1 | Store can take a byte |
| cts | input | 1 | Echoed wired-AND line value |
| txd | output | 1 | Open-drain style line drive, 1 means released |
| done | output | 1 | One-cycle pulse at the end of a successful frame |
| coll | output | 1 | One-cycle pulse after a lost arbitration |
| coll_cnt | output | CNT_W | Count of lost arbitrations, wraps |

## Verification
The bench models the line as the AND of `txd` and a second station's drive. It forces that station low at chosen bit offsets relative to the first flag bit it observes. The delicate overlap is where arbitration meets the frame's own sequencing. One case is a zero-bit insertion or a flag zero that coincides with the other station pulling low, which must not count as a loss. Another is a loss on the last one of the closing flag, in the very cycle before completion would have fired, which must give a retry and no `done`. Each case is judged by the recorded tail of the `txd` stream against a frame built in the bench, by the exact cycle of the `coll` pulse, and by the number of `done` pulses.

// File: rtl/hdlc_bus_pkg.sv
package hdlc_bus_pkg;
  typedef enum logic [2:0] {
    ST_LOAD,
    ST_HUNT,
    ST_OPEN,
    ST_DATA,
    ST_CLOSE,
    ST_FIN
  } tx_state_e;

  localparam logic [7:0] HDLC_FLAG = 8'h7E;
  localparam int STUFF_RUN = 5;
endpackage

// File: rtl/hdlc_frame_store.sv
module hdlc_frame_store #(
  parameter int DEPTH = 16,
  parameter int AW = $clog2(DEPTH),
  parameter int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    wr_data,
  input  logic          wr_valid,
  input  logic          wr_sof,
  input  logic          wr_eof,
  output logic          wr_ready,
  input  logic          release_i,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [LW-1:0] frame_len,
  output logic          frame_rdy
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] widx;
  logic          accept;
  logic          closing;

  assign accept   = wr_valid && !frame_rdy;
  assign widx     = wr_sof ? '0 : wr_ptr;
  assign closing  = wr_eof || (widx == AW'(DEPTH - 1));
  assign wr_ready = !frame_rdy;

  always_ff @(posedge clk) begin
    if (accept) mem[widx] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_rdy <= 1'b0;
      wr_ptr    <= '0;
      frame_len <= '0;
    end else if (release_i) begin
      frame_rdy <= 1'b0;
    end else if (accept) begin
      if (closing) begin
        frame_rdy <= 1'b1;
        frame_len <= LW'(widx) + LW'(1);
        wr_ptr    <= '0;
      end else begin
        wr_ptr <= widx + AW'(1);
      end
    end
  end

  AST_FRAME_HELD: assert property (@(posedge clk) disable iff (rst)
    frame_rdy && !release_i |=> frame_rdy); // R2
endmodule

// File: rtl/hdlc_idle_hunt.sv
module hdlc_idle_hunt #(
  parameter int IDLE_ONES = 8,
  parameter int CW = $clog2(IDLE_ONES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic hunt_en,
  input  logic cts,
  output logic bus_free
);
  logic [CW-1:0] ones_cnt;

  assign bus_free = hunt_en && cts && (ones_cnt == CW'(IDLE_ONES - 1));

  always_ff @(posedge clk) begin
    if (rst || !hunt_en || !cts || bus_free) ones_cnt <= '0;
    else ones_cnt <= ones_cnt + CW'(1);
  end

  AST_HUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    ones_cnt < CW'(IDLE_ONES)); // R3
endmodule

// File: rtl/hdlc_arb_monitor.sv
module hdlc_arb_monitor #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             live,
  input  logic             sent,
  input  logic             cts,
  output logic             lost,
  output logic             coll_pulse,
  output logic [CNT_W-1:0] coll_cnt
);
  assign lost = live && sent && !cts;

  always_ff @(posedge clk) begin
    if (rst) begin
      coll_pulse <= 1'b0;
      coll_cnt   <= '0;
    end else begin
      coll_pulse <= lost;
      if (lost) coll_cnt <= coll_cnt + CNT_W'(1);
    end
  end

  AST_COLL_STEP: assert property (@(posedge clk) disable iff (rst)
    lost |=> coll_pulse && (coll_cnt == $past(coll_cnt) + CNT_W'(1))); // R7
endmodule

// File: rtl/hdlc_bus_tx.sv
module hdlc_bus_tx
  import hdlc_bus_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int IDLE_ONES = 8,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic             in_ready,
  input  logic             cts,
  output logic             txd,
  output logic             done,
  output logic             coll,
  output logic [CNT_W-1:0] coll_cnt
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  tx_state_e     state;
  logic          txd_q;
  logic          live_q;
  logic          done_q;
  logic [2:0]    bit_cnt;
  logic [2:0]    ones_run;
  logic [7:0]    shreg;
  logic [LW-1:0] byte_idx;
  logic [7:0]    rd_data;
  logic [LW-1:0] frame_len;
  logic          frame_rdy;
  logic          bus_free;
  logic          lost;
  logic          release_frame;
  logic          stuff_due;

  assign release_frame = (state == ST_FIN) && !lost;
  assign stuff_due     = (ones_run == 3'(STUFF_RUN));

  hdlc_frame_store #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_data   (in_data),
    .wr_valid  (in_valid),
    .wr_sof    (in_sof),
    .wr_eof    (in_eof),
    .wr_ready  (in_ready),
    .release_i (release_frame),
    .rd_addr   (byte_idx[AW-1:0]),
    .rd_data   (rd_data),
    .frame_len (frame_len),
    .frame_rdy (frame_rdy)
  );

  hdlc_idle_hunt #(.IDLE_ONES(IDLE_ONES)) u_hunt (
    .clk      (clk),
    .rst      (rst),
    .hunt_en  (state == ST_HUNT),
    .cts      (cts),
    .bus_free (bus_free)
  );

  hdlc_arb_monitor #(.CNT_W(CNT_W)) u_arb (
    .clk        (clk),
    .rst        (rst),
    .live       (live_q),
    .sent       (txd_q),
    .cts        (cts),
    .lost       (lost),
    .coll_pulse (coll),
    .coll_cnt   (coll_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_LOAD;
      txd_q    <= 1'b1;
      live_q   <= 1'b0;
      done_q   <= 1'b0;
      bit_cnt  <= '0;
      ones_run <= '0;
      shreg    <= '0;
      byte_idx <= '0;
    end else begin
      done_q <= 1'b0;
      if (lost) begin
        state    <= ST_HUNT;
        txd_q    <= 1'b1;
        live_q   <= 1'b0;
        bit_cnt  <= '0;
        ones_run <= '0;
        byte_idx <= '0;
      end else begin
        case (state)
          ST_LOAD: if (frame_rdy) state <= ST_HUNT;
          ST_HUNT: begin
            if (bus_free) begin
              state   <= ST_OPEN;
              txd_q   <= HDLC_FLAG[0];
              live_q  <= 1'b1;
              bit_cnt <= 3'd1;
            end
          end
          ST_OPEN: begin
            txd_q   <= HDLC_FLAG[bit_cnt];
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              state    <= ST_DATA;
              shreg    <= rd_data;
              byte_idx <= byte_idx + LW'(1);
              ones_run <= '0;
            end
          end
          ST_DATA: begin
            if (stuff_due) begin
              txd_q    <= 1'b0;
              ones_run <= '0;
            end else begin
              txd_q    <= shreg[0];
              shreg    <= shreg >> 1;
              ones_run <= shreg[0] ? ones_run + 3'd1 : 3'd0;
              bit_cnt  <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) begin
                if (byte_idx == frame_len) begin
                  state <= ST_CLOSE;
                end else begin
                  shreg    <= rd_data;
                  byte_idx <= byte_idx + LW'(1);
                end
              end
            end
          end
          ST_CLOSE: begin
            if (stuff_due) begin
              txd_q    <= 1'b0;
              ones_run <= '0;
            end else begin
              txd_q   <= HDLC_FLAG[bit_cnt];
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) state <= ST_FIN;
            end
          end
          ST_FIN: begin
            txd_q    <= 1'b1;
            live_q   <= 1'b0;
            done_q   <= 1'b1;
            byte_idx <= '0;
            state    <= ST_LOAD;
          end
          default: state <= ST_LOAD;
        endcase
      end
    end
  end

  assign txd  = txd_q;
  assign done = done_q;

  AST_HUNT_TXD_HIGH: assert property (@(posedge clk) disable iff (rst)
    state == ST_HUNT |-> txd_q); // R3
  AST_LOSS_RELEASE: assert property (@(posedge clk) disable iff (rst)
    lost |=> txd_q && (state == ST_HUNT) && !done_q); // R7
  AST_STUFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA || state == ST_CLOSE) && stuff_due && !lost |=> !txd_q); // R5
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
    ones_run <= 3'(STUFF_RUN)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R9
endmodule

// File: tb/test_hdlc_bus_tx.sv
`timescale 1ns/1ps
module test_hdlc_bus_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_sof = 1'b0;
  logic       in_eof = 1'b0;
  logic       in_ready;
  logic       txd;
  logic       done;
  logic       coll;
  logic [7:0] coll_cnt;
  logic       other = 1'b1;
  logic       cts;

  assign cts = txd & other;

  always #2.5 clk = ~clk;

  hdlc_bus_tx i_hdlc_bus_tx (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_sof(in_sof), .in_eof(in_eof), .in_ready(in_ready), .cts(cts),
    .txd(txd), .done(done), .coll(coll), .coll_cnt(coll_cnt)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [7:0] fb [32];
  bit rec [4096];
  bit exp_bits [1024];
  int rec_n;
  int exp_n;
  bit done_seen;

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic load_frame(int n, bit with_eof);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = fb[i];
      in_sof   = (i == 0);
      in_eof   = with_eof && (i == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic build_exp(int n);
    int run = 0;
    exp_n = 0;
    for (int i = 0; i < 8; i++) exp_bits[exp_n++] = (8'h7E >> i) & 1;
    for (int k = 0; k < n; k++) begin
      for (int b = 0; b < 8; b++) begin
        exp_bits[exp_n++] = fb[k][b];
        run = fb[k][b] ? run + 1 : 0;
        if (run == 5) begin exp_bits[exp_n++] = 1'b0; run = 0; end
      end
    end
    for (int i = 0; i < 8; i++) exp_bits[exp_n++] = (8'h7E >> i) & 1;
  endtask

  task automatic capture(int zero_off, int hit_off);
    int start = -1;
    int pos;
    int c0 = 0;
    bit hit_done = 0;
    bit chk_hit = 0;
    bit chk_zero = 0;
    rec_n = 0;
    done_seen = 0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      if (chk_hit) begin
        check(txd == 1'b1, "R7 txd released after loss", txd, 1);
        check(coll == 1'b1, "R7 coll pulse", coll, 1);
        check(coll_cnt == 8'(c0 + 1), "R7 coll_cnt step", coll_cnt, c0 + 1);
        chk_hit = 0;
      end
      if (chk_zero) begin
        check(coll == 1'b0, "R6 zero overlap not a loss", coll, 0);
        chk_zero = 0;
      end
      if (done) begin done_seen = 1; break; end
      rec[rec_n] = txd;
      if (start < 0 && txd == 1'b0) start = rec_n;
      pos = (start < 0) ? -1 : rec_n - start;
      rec_n++;
      other = 1'b1;
      if (!hit_done && start >= 0 && pos == zero_off) begin
        other = 1'b0; chk_zero = 1;
      end
      if (!hit_done && start >= 0 && pos == hit_off) begin
        other = 1'b0; hit_done = 1; chk_hit = 1; c0 = coll_cnt;
      end
    end
    other = 1'b1;
  endtask

  task automatic judge_frame(string tag);
    int mism = 0;
    if (rec_n < exp_n) mism = exp_n;
    else for (int k = 0; k < exp_n; k++)
      if (rec[rec_n - exp_n + k] != exp_bits[k]) mism++;
    check(done_seen, {tag, " done seen"}, done_seen, 1);
    check(mism == 0, {tag, " bit stream mismatches"}, mism, 0);
    @(negedge clk);
    check(done == 1'b0, "R9 done single pulse", done, 0);
    check(in_ready == 1'b1, "R9 in_ready back after done", in_ready, 1);
  endtask

  task automatic t_reset;
    check(txd == 1'b1, "R1 txd idle", txd, 1);
    check(done == 1'b0, "R1 done low", done, 0);
    check(coll == 1'b0 && coll_cnt == 0, "R1 coll clear", coll_cnt, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
  endtask

  task automatic t_basic;
    fb[0] = 8'h01; fb[1] = 8'hA5;
    build_exp(2);
    load_frame(2, 1);
    check(in_ready == 1'b0, "R2 ready low while frame held", in_ready, 1'b0);
    capture(-1, -1);
    judge_frame("R4 basic");
    check(coll_cnt == 0, "R6 no loss on clean line", coll_cnt, 0);
  endtask

  task automatic t_stuff;
    fb[0] = 8'hFF; fb[1] = 8'hF8;
    build_exp(2);
    load_frame(2, 1);
    capture(-1, -1);
    judge_frame("R5 stuffing");
  endtask

  task automatic t_hunt;
    int k = 0;
    other = 1'b0;
    fb[0] = 8'h3C;
    load_frame(1, 1);
    repeat (6) @(negedge clk);
    check(txd == 1'b1, "R3 deferral while line low", txd, 1);
    other = 1'b1;
    repeat (4) @(negedge clk);
    check(txd == 1'b1, "R3 no start after four ones", txd, 1);
    other = 1'b0;
    @(negedge clk);
    other = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      k++;
      if (txd == 1'b0) break;
    end
    check(k == 8, "R3 flag after eight fresh ones", k, 8);
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (done) break;
    end
    @(negedge clk);
  endtask

  task automatic t_collide_early;
    fb[0] = 8'h7E; fb[1] = 8'h12;
    build_exp(2);
    load_frame(2, 1);
    capture(0, 2);
    judge_frame("R8 retry after early loss");
    check(coll_cnt == 1, "R7 one loss counted", coll_cnt, 1);
  endtask

  task automatic t_collide_late;
    fb[0] = 8'h81;
    build_exp(1);
    load_frame(1, 1);
    capture(-1, exp_n - 2);
    judge_frame("R8 retry after closing-flag loss");
    check(coll_cnt == 2, "R7 second loss counted", coll_cnt, 2);
  endtask

  task automatic t_overflow;
    other = 1'b0;
    for (int i = 0; i < 16; i++) fb[i] = 8'(8'h10 + i * 7);
    build_exp(16);
    load_frame(16, 0);
    check(in_ready == 1'b0, "R2 full store closes frame", in_ready, 0);
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h55; in_eof = 1'b1;
    repeat (2) @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0;
    capture(-1, -1);
    judge_frame("R2 overflow byte ignored");
  endtask

  task automatic t_sof_restart;
    other = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_sof = 1'b1; in_data = 8'hAA;
    @(negedge clk);
    in_sof = 1'b0; in_data = 8'hBB;
    @(negedge clk);
    in_sof = 1'b1; in_eof = 1'b1; in_data = 8'h11;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    fb[0] = 8'h11;
    build_exp(1);
    capture(-1, -1);
    judge_frame("R2 sof restart");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_stuff();
    t_hunt();
    t_collide_early();
    t_collide_late();
    t_overflow();
    t_sof_restart();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule